// File: doc/BRIEF.md
# TPM SPI Register Access Engine

This block is the host end of a serial link to a trusted platform module. A local agent asks for one register access by giving a direction, a 12-bit register offset, a byte count and, for a write, a stream of data bytes. The engine then runs one complete SPI transaction in mode 0. It lowers chip select and shifts out a four-byte header. The header is a command byte followed by a 24-bit address. The engine then moves the data bytes and raises chip select again.

The command byte holds the direction in its top bit and the byte count less one in its low bits. The upper address byte is always the fixed 0xD4 window, because the device ignores any access outside that window and answers reads with 0xFF bytes. The lower two address bytes hold the zero-extended register offset. Read bytes come back one at a time with a valid strobe, in the order they cross the wire. The engine fetches write bytes one at a time through a take strobe. A one-cycle done pulse closes every accepted transaction. A request with an unusable byte count gets a one-cycle error pulse, and the bus stays quiet.

Top module: `tpm_reg_spi_master`

## Requirements
- R1: Command byte bit 7 is 1 for a read request and 0 for a write request.
- R2: Command byte bits 5:0 carry the byte count minus one, and bit 6 is 0. For example, a 4-byte read sends 0x83 and a 1-byte write sends 0x00.
- R3: Three address bytes follow the command byte, most significant first: 0xD4, then bits 15:8 of the zero-extended offset, then bits 7:0. Offset 0x018 is sent as D4 00 18.
- R4: SPI mode 0. SCLK rests low whenever chip select is high. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge. Every byte travels MSB first.
- R5: Chip select falls once per accepted request and stays low for exactly 8×(4+length) SCLK rising edges. It rises together with the done pulse.
- R6: For a read, each data byte appears on rdData with a one-cycle rdValid strobe, in wire order, exactly length times. A write produces no rdValid.
- R7: For a write, wrTake pulses once per data byte, and wrData is captured in that cycle. The captured bytes are shifted out in the order they were taken.
- R8: A request with length 0 or length above 64 raises err for one cycle. It produces no chip select activity and no done pulse.
- R9: Each SCLK half period lasts HALF_DIV system clock cycles, and the first rising edge comes HALF_DIV cycles after chip select falls.
- R10: busy is high from acceptance until done. A request presented while busy is ignored.
- R11: After reset, chip select is high, SCLK is low, and busy, done, err, rdValid and wrTake are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Register offset |
| reqLen | input | LEN_W | Byte count, valid range 1 to MAX_LEN |
| wrData | input | 8 | Write byte, captured when wrTake is high |
| wrTake | output | 1 | Write byte consumed this cycle |
| rdData | output | 8 | Read byte |
| rdValid | output | 1 | rdData holds a new byte |
| done | output | 1 | Transaction finished |
| err | output | 1 | Request rejected because of its length |
| busy | output | 1 | Transaction in progress |
| spiCsN | output | 1 | Chip select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device |

## Verification
A wrong byte index or source select in the control shows up in the first header byte after it. A slave model that records MOSI sees the bad byte within eight SCLK periods. A bit counter or divider that slips changes the count of rising edges inside the chip select window and the spacing between them. The half-period checker catches a slip on the next SCLK toggle. A faulty direction latch shows up before done, either as missing or extra rdValid strobes or as a wrong wrTake count.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;

  localparam int HDR_BYTES = 4;
  localparam logic [7:0] ADDR_WINDOW = 8'hD4;

  typedef enum logic [2:0] {
    SRC_CMD   = 3'd0,
    SRC_WIN   = 3'd1,
    SRC_AMID  = 3'd2,
    SRC_ALO   = 3'd3,
    SRC_WDATA = 3'd4,
    SRC_FILL  = 3'd5
  } txSrc_t;

  typedef struct packed {
    logic   capture;
    logic   loadTx;
    txSrc_t txSel;
    logic   run;
    logic   pushRx;
    logic   finish;
  } ctrlStrobe_t;

endpackage

// File: rtl/tpm_spi_ctrl.sv
module tpm_spi_ctrl
  import tpm_spi_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             byteEnd,
  output ctrlStrobe_t      strobe,
  output logic             wrTake,
  output logic             busy,
  output logic             done,
  output logic             err
);

  localparam int IDX_W = $clog2(MAX_LEN + HDR_BYTES);

  typedef enum logic {ST_IDLE, ST_XFER} ctrlState_t;

  ctrlState_t state;
  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             isWrite;
  logic             lenOk;

  assign lenOk   = (reqLen != '0) && (reqLen <= LEN_W'(MAX_LEN));
  assign nextIdx = byteIdx + IDX_W'(1);

  always_comb begin
    strobe = '0;
    strobe.txSel = SRC_CMD;
    if (state == ST_IDLE) begin
      if (reqValid && lenOk) begin
        strobe.capture = 1'b1;
        strobe.loadTx  = 1'b1;
      end
    end else begin
      strobe.run = 1'b1;
      if (byteEnd) begin
        strobe.pushRx = !isWrite && (byteIdx >= IDX_W'(HDR_BYTES));
        if (byteIdx == lastIdx) begin
          strobe.finish = 1'b1;
        end else begin
          strobe.loadTx = 1'b1;
          if (nextIdx < IDX_W'(HDR_BYTES))
            strobe.txSel = txSrc_t'(nextIdx[2:0]);
          else
            strobe.txSel = isWrite ? SRC_WDATA : SRC_FILL;
        end
      end
    end
  end

  assign wrTake = strobe.loadTx && (strobe.txSel == SRC_WDATA);
  assign busy   = (state == ST_XFER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
      lastIdx <= '0;
      isWrite <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= strobe.finish;
      err  <= (state == ST_IDLE) && reqValid && !lenOk;
      if (strobe.capture) begin
        state   <= ST_XFER;
        byteIdx <= '0;
        lastIdx <= IDX_W'(reqLen) + IDX_W'(HDR_BYTES - 1);
        isWrite <= reqWrite;
      end else if (strobe.finish) begin
        state <= ST_IDLE;
      end else if (strobe.loadTx) begin
        byteIdx <= nextIdx;
      end
    end
  end

endmodule

// File: rtl/tpm_spi_datapath.sv
module tpm_spi_datapath
  import tpm_spi_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 12,
  parameter int LEN_W    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        wrData,
  input  logic              miso,
  output logic              byteEnd,
  output logic              sclk,
  output logic              mosi,
  output logic              csN,
  output logic [7:0]        rdData,
  output logic              rdValid
);

  localparam int DIV_W = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

  logic [ADDR_W-1:0] addrReg;
  logic [15:0]       offset16;
  logic [7:0]        cmdByte;
  logic [7:0]        selByte;
  logic [7:0]        txShift;
  logic [7:0]        rxShift;
  logic [DIV_W-1:0]  halfCnt;
  logic [2:0]        bitCnt;
  logic              halfEnd;

  assign offset16 = 16'(addrReg);
  assign cmdByte  = {~reqWrite, 7'(reqLen - LEN_W'(1))};
  assign halfEnd  = strobe.run && (halfCnt == DIV_W'(HALF_DIV - 1));
  assign byteEnd  = halfEnd && sclk && (bitCnt == 3'd7);
  assign mosi     = txShift[7];

  always_comb begin
    case (strobe.txSel)
      SRC_CMD:   selByte = cmdByte;
      SRC_WIN:   selByte = ADDR_WINDOW;
      SRC_AMID:  selByte = offset16[15:8];
      SRC_ALO:   selByte = offset16[7:0];
      SRC_WDATA: selByte = wrData;
      default:   selByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      txShift <= '0;
      rxShift <= '0;
      halfCnt <= '0;
      bitCnt  <= '0;
      sclk    <= 1'b0;
      csN     <= 1'b1;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.pushRx;
      if (strobe.pushRx) rdData <= rxShift;

      if (strobe.capture) begin
        addrReg <= reqAddr;
        csN     <= 1'b0;
      end else if (strobe.finish) begin
        csN <= 1'b1;
      end

      if (!strobe.run || halfEnd) halfCnt <= '0;
      else                        halfCnt <= halfCnt + DIV_W'(1);

      if (!strobe.run) begin
        sclk   <= 1'b0;
        bitCnt <= '0;
      end else if (halfEnd) begin
        sclk <= ~sclk;
        if (!sclk) rxShift <= {rxShift[6:0], miso};
        else       bitCnt  <= bitCnt + 3'd1;
      end

      if (strobe.loadTx)       txShift <= selByte;
      else if (halfEnd && sclk) txShift <= {txShift[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/tpm_reg_spi_master.sv
module tpm_reg_spi_master
  import tpm_spi_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int MAX_LEN  = 64,
  parameter int ADDR_W   = 12,
  parameter int LEN_W    = $clog2(MAX_LEN) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [7:0]        wrData,
  output logic              wrTake,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              done,
  output logic              err,
  output logic              busy,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  input  logic              spiMiso
);

  ctrlStrobe_t strobe;
  logic        byteEnd;

  tpm_spi_ctrl #(
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqLen  (reqLen),
    .byteEnd (byteEnd),
    .strobe  (strobe),
    .wrTake  (wrTake),
    .busy    (busy),
    .done    (done),
    .err     (err)
  );

  tpm_spi_datapath #(
    .HALF_DIV(HALF_DIV),
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqLen  (reqLen),
    .wrData  (wrData),
    .miso    (spiMiso),
    .byteEnd (byteEnd),
    .sclk    (spiSclk),
    .mosi    (spiMosi),
    .csN     (spiCsN),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/tpm_spi_checker.sv
module tpm_spi_checker #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rstN,
  input logic wrTake,
  input logic rdValid,
  input logic done,
  input logic err,
  input logic busy,
  input logic spiCsN,
  input logic spiSclk,
  input logic spiMosi
);

  logic        lastSclk;
  logic [15:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastSclk <= 1'b0;
      holdCnt  <= '0;
    end else begin
      lastSclk <= spiSclk;
      if (spiCsN)                  holdCnt <= '0;
      else if (spiSclk != lastSclk) holdCnt <= 16'd1;
      else                          holdCnt <= holdCnt + 16'd1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);  // R4

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi));  // R4

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && (spiSclk != lastSclk)) |-> (holdCnt == 16'(HALF_DIV)));  // R9

  AST_CS_RISE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> done);  // R5

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (spiCsN && !busy && !done));  // R8

  AST_TAKE_IN_XFER: assert property (@(posedge clk) disable iff (!rstN)
    wrTake |-> (busy && !spiCsN && !rdValid));  // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R10

endmodule

bind tpm_reg_spi_master tpm_spi_checker #(.HALF_DIV(HALF_DIV)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .wrTake (wrTake),
  .rdValid(rdValid),
  .done   (done),
  .err    (err),
  .busy   (busy),
  .spiCsN (spiCsN),
  .spiSclk(spiSclk),
  .spiMosi(spiMosi)
);

// File: tb/sim_tpm_reg_spi_master.sv
`timescale 1ns/1ps
module sim_tpm_reg_spi_master;

  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [6:0]  reqLen = '0;
  logic [7:0]  wrData;
  logic wrTake, rdValid, done, err, busy;
  logic [7:0] rdData;
  logic spiCsN, spiSclk, spiMosi;
  logic spiMiso = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  tpm_reg_spi_master #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .wrData(wrData), .wrTake(wrTake),
    .rdData(rdData), .rdValid(rdValid), .done(done), .err(err), .busy(busy),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // write source
  logic [7:0] wrBuf [0:63];
  int wrIdx = 0;
  bit takeSeen = 0;
  assign wrData = wrBuf[wrIdx & 63];

  // observers
  logic [7:0] rdBuf [0:79];
  int rdCnt = 0, doneCnt = 0, errCnt = 0, takeCnt = 0;
  int csFallCyc = -1, rise0 = -1, rise1 = -1;
  logic prevSclk = 0, prevCs = 1;

  always @(negedge clk) begin
    cyc++;
    if (takeSeen) wrIdx++;
    takeSeen = wrTake;
    if (wrTake) takeCnt++;
    if (rdValid) begin rdBuf[rdCnt % 80] = rdData; rdCnt++; end
    if (done) doneCnt++;
    if (err) errCnt++;
    if (prevCs && !spiCsN && csFallCyc < 0) csFallCyc = cyc;
    if (spiSclk && !prevSclk) begin
      if (rise0 < 0) rise0 = cyc;
      else if (rise1 < 0) rise1 = cyc;
    end
    prevSclk = spiSclk;
    prevCs = spiCsN;
  end

  // slave device model
  logic [7:0] slvBytes [0:79];
  int sBit = 0, sByte = 0, csFalls = 0, rises = 0;
  logic [7:0] inSh = 0, outSh = 0;

  function automatic logic [7:0] pat(int k, logic [7:0] lo);
    return 8'((k * 37) + lo + 8'h5B);
  endfunction

  always @(negedge spiCsN) begin
    sBit = 0; sByte = 0; outSh = 0; spiMiso = 0; csFalls++;
  end
  always @(posedge spiSclk) if (!spiCsN) begin
    inSh = {inSh[6:0], spiMosi};
    sBit++; rises++;
    if (sBit == 8) begin
      slvBytes[sByte % 80] = inSh; sByte++; sBit = 0;
    end
  end
  always @(negedge spiSclk) if (!spiCsN) begin
    if (sBit == 0) begin
      if (sByte >= 4 && slvBytes[0][7])
        outSh = (slvBytes[1] == 8'hD4) ? pat(sByte - 4, slvBytes[3]) : 8'hFF;
      else
        outSh = 8'h00;
    end else begin
      outSh = {outSh[6:0], 1'b0};
    end
    spiMiso = outSh[7];
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearObs();
    rdCnt = 0; doneCnt = 0; errCnt = 0; takeCnt = 0;
    csFalls = 0; rises = 0; sByte = 0;
    csFallCyc = -1; rise0 = -1; rise1 = -1;
  endtask

  task automatic issue(bit w, logic [11:0] a, logic [6:0] n);
    @(negedge clk);
    reqValid = 1; reqWrite = w; reqAddr = a; reqLen = n;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000 && doneCnt == 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkHeader(bit w, logic [11:0] a, logic [6:0] n);
    logic [7:0] cmd;
    cmd = {~w, 1'b0, 6'(n - 1)};
    check(slvBytes[0][7] == ~w, "R1", "direction bit", slvBytes[0][7], ~w);
    check(slvBytes[0] == cmd, "R2", "command byte", slvBytes[0], cmd);
    check(slvBytes[1] == 8'hD4 && slvBytes[2] == {4'h0, a[11:8]} && slvBytes[3] == a[7:0],
          "R3", "address bytes", {slvBytes[1], slvBytes[2], slvBytes[3]}, {8'hD4, 4'h0, a});
    check(csFalls == 1, "R5", "cs falls", csFalls, 1);
    check(rises == 8 * (4 + n), "R5", "sclk rises", rises, 8 * (4 + n));
    check(doneCnt == 1 && !busy && spiCsN, "R10", "done/busy", doneCnt, 1);
  endtask

  task automatic testReset();
    check(spiCsN && !spiSclk && !busy && !done && !err && !rdValid && !wrTake,
          "R11", "reset outputs", {spiCsN, spiSclk, busy, done, err, rdValid, wrTake}, 7'b1000000);
  endtask

  task automatic testRead(logic [11:0] a, logic [6:0] n, bit timing);
    int mism = 0;
    clearObs();
    issue(0, a, n);
    waitDone();
    checkHeader(0, a, n);
    check(rdCnt == n, "R6", "read byte count", rdCnt, n);
    for (int k = 0; k < n; k++) if (rdBuf[k] != pat(k, a[7:0])) mism++;
    check(mism == 0, "R6", "read byte order/value mismatches", mism, 0);
    check(slvBytes[4] == 8'h00, "R4", "read fill byte", slvBytes[4], 0);
    if (timing) begin
      check(rise1 - rise0 == 2 * HALF, "R9", "sclk period", rise1 - rise0, 2 * HALF);
      check(rise0 - csFallCyc == HALF, "R9", "cs to first rise", rise0 - csFallCyc, HALF);
    end
  endtask

  task automatic testWrite(logic [11:0] a, logic [6:0] n, logic [7:0] seed);
    int mism = 0;
    for (int k = 0; k < 64; k++) wrBuf[k] = 8'((k * 29) ^ seed);
    wrIdx = 0;
    clearObs();
    issue(1, a, n);
    waitDone();
    checkHeader(1, a, n);
    check(takeCnt == n, "R7", "take count", takeCnt, n);
    for (int k = 0; k < n; k++) if (slvBytes[4 + k] != wrBuf[k]) mism++;
    check(mism == 0, "R7", "written byte mismatches", mism, 0);
    check(rdCnt == 0, "R6", "no read strobes on write", rdCnt, 0);
  endtask

  task automatic testBadLen(logic [6:0] n);
    clearObs();
    issue(0, 12'h018, n);
    repeat (10) @(negedge clk);
    check(errCnt == 1, "R8", "err pulses", errCnt, 1);
    check(csFalls == 0 && doneCnt == 0 && !busy, "R8", "quiet bus", csFalls + doneCnt, 0);
  endtask

  task automatic testBusyIgnore();
    clearObs();
    issue(0, 12'h024, 7'd2);
    repeat (20) @(negedge clk);
    issue(1, 12'h3C0, 7'd5);
    waitDone();
    checkHeader(0, 12'h024, 7'd2);
    check(takeCnt == 0 && rdCnt == 2, "R10", "second request ignored", takeCnt, 0);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) wrBuf[k] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    repeat (2) @(negedge clk);
    testRead(12'h018, 7'd4, 1);
    testWrite(12'h0A5, 7'd3, 8'hC3);
    testRead(12'hFFF, 7'd64, 0);
    testWrite(12'h100, 7'd1, 8'h7E);
    testWrite(12'h024, 7'd64, 8'h11);
    testRead(12'h000, 7'd1, 0);
    testBadLen(7'd0);
    testBadLen(7'd65);
    testBadLen(7'd127);
    testBusyIgnore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule